// File: doc/BRIEF.md
# Real-time clock register window and update sequencer

This block is the software-visible face of a real-time clock. A host reaches it through a two-location byte port. The even location holds a register index. The odd location reads or writes the register chosen by that index. Behind the port the block keeps the rate/control, mode, flag and status registers and three alarm bytes. The calendar itself is a separate block. It publishes seconds, minutes and hours on a time bus, and this window returns those values when the host reads the time indices.

Once per second a prescaler pulses `secTick`. If the divider field allows it and the clock is not in set mode, the block runs an update cycle. It first raises the update-in-progress flag for a fixed lead window. It then asks the calendar to advance. Finally it closes the update: it drops the flag, compares the new time against the alarm bytes and posts interrupt flags. The flags collect in a status byte whose top bit drives `irq`, and reading that byte clears it.

Set mode lets software load a new time without the calendar moving underneath it. While set mode is active the block raises `calHold`. When software leaves set mode, the block pulses `calLoad` so that the calendar reloads.

Top module: `rtc_core`

## Requirements
- R1: A write with `busAddr`=0 stores `busWdata[6:0]` as the index, and bit 7 is dropped. Reads and writes with `busAddr`=1 reach the register at that index. The map is: 1, 3, 5 = seconds/minutes/hours alarm; 10 = rate/control; 11 = mode; 12 = flags; 13 = status.
- R2: After reset, rate/control reads 0x26, mode reads 0x02, flags read 0x00, status reads 0x80 and the alarm bytes read 0x00.
- R3: Bit 7 of rate/control is the update-in-progress flag and cannot be written. A write to index 10 changes only bits 6:0.
- R4: Writing mode bit 7 (set mode) as 1 clears update-in-progress in the next cycle and cancels any pending advance or update end. While that bit is 1, `calHold` is high and ticks are ignored. Writing it back to 0 while it was 1 pulses `calLoad` for one cycle, starting the next cycle.
- R5: A tick starts an update only while rate/control bits 6:4 equal 010. Otherwise it has no effect.
- R6: After an accepted tick, update-in-progress is 1 for LEAD_CYCLES+2 cycles. `calAdvance` pulses for one cycle in the last-but-one of those cycles. The flag clears when the update ends, in the cycle after the advance.
- R7: An alarm byte whose bits 7:6 are 11 matches any value; any other alarm byte must equal its time bus byte. If all three alarm bytes match at update end and mode bit 5 is 1, flag bits 7 and 5 are set.
- R8: At every update end with mode bit 4 set, flag bits 7 and 4 are set.
- R9: A read of index 12 returns the flags and then clears them. Flags posted by an update end in the same cycle survive the clear.
- R10: Writes to indices 12 and 13 are ignored, and index 13 always reads 0x80.
- R11: `irq` equals flag bit 7.
- R12: Indices 0, 2 and 4 read `timeSec`, `timeMin` and `timeHour`. Unmapped indices, and any cycle without a read at `busAddr`=1, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busAddr | input | 1 | 0 = index location, 1 = data location |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid while `busRe` is high |
| secTick | input | 1 | One-cycle once-per-second strobe |
| timeSec | input | 8 | Current seconds from the calendar |
| timeMin | input | 8 | Current minutes from the calendar |
| timeHour | input | 8 | Current hours from the calendar |
| calAdvance | output | 1 | Request to advance the calendar by one second |
| calHold | output | 1 | Set mode active; calendar must not move |
| calLoad | output | 1 | One-cycle pulse when set mode is left |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a read and a write never share a cycle, and that `secTick` is a single-cycle pulse spaced more than LEAD_CYCLES+3 cycles from the next one. They also assume that the time bus changes only in response to `calAdvance`. The stimulus issues one bus operation at a time and drives the time bus from its own model calendar, which steps only on the advance request. It leaves a full update window between ticks, except where it deliberately enters set mode or reads the flags in the middle of an update.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 7;
  localparam int ALARM_N = 3;

  localparam logic [IDX_W-1:0] IX_SEC   = 7'd0;
  localparam logic [IDX_W-1:0] IX_MIN   = 7'd2;
  localparam logic [IDX_W-1:0] IX_HOUR  = 7'd4;
  localparam logic [IDX_W-1:0] IX_RATE  = 7'd10;
  localparam logic [IDX_W-1:0] IX_MODE  = 7'd11;
  localparam logic [IDX_W-1:0] IX_FLAG  = 7'd12;
  localparam logic [IDX_W-1:0] IX_STAT  = 7'd13;

  localparam logic [DATA_W-1:0] RATE_RST = 8'h26;
  localparam logic [DATA_W-1:0] MODE_RST = 8'h02;
  localparam logic [DATA_W-1:0] STAT_VAL = 8'h80;
  localparam logic [2:0]        DIV_RUN  = 3'b010;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LEAD,
    PH_ADV,
    PH_DONE
  } upd_phase_t;

  typedef struct packed {
    logic raiseUip;
    logic advance;
    logic finish;
  } upd_strobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int LEAD_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        secTick,
  input  logic        dividerOk,
  input  logic        setMode,
  output upd_strobe_t strobe
);
  localparam int CNT_W = $clog2(LEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LEAD_CYCLES - 1);

  upd_phase_t phase;
  logic [CNT_W-1:0] leadCnt;

  always_comb begin
    strobe.raiseUip = (phase == PH_IDLE) && secTick && dividerOk && !setMode;
    strobe.advance  = (phase == PH_ADV) && !setMode;
    strobe.finish   = (phase == PH_DONE) && !setMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      leadCnt <= '0;
    end else if (phase != PH_IDLE && setMode) begin
      phase   <= PH_IDLE;
      leadCnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          leadCnt <= '0;
          if (strobe.raiseUip) phase <= PH_LEAD;
        end
        PH_LEAD: begin
          if (leadCnt == CNT_LAST) phase <= PH_ADV;
          else leadCnt <= leadCnt + 1'b1;
        end
        PH_ADV:  phase <= PH_DONE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_lead_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LEAD) |-> (leadCnt <= CNT_LAST));

  assert_adv_after_lead_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> ($past(phase) == PH_LEAD));
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] timeSec,
  input  logic [DATA_W-1:0] timeMin,
  input  logic [DATA_W-1:0] timeHour,
  input  upd_strobe_t       strobe,
  output logic              dividerOk,
  output logic              setMode,
  output logic              calLoad,
  output logic              irq
);
  logic [IDX_W-1:0]  idxReg;
  logic [DATA_W-2:0] rateReg;
  logic              uipFlag;
  logic [DATA_W-1:0] modeReg;
  logic [DATA_W-1:0] flagReg;
  logic [DATA_W-1:0] flagNext;
  logic [DATA_W-1:0] alarmReg [ALARM_N];
  logic [DATA_W-1:0] timeVec  [ALARM_N];
  logic [ALARM_N-1:0] alarmHit;

  logic wrIndex, wrData, rdData, wrMode, rdFlag;

  assign wrIndex = busWe && !busAddr;
  assign wrData  = busWe && busAddr;
  assign rdData  = busRe && busAddr;
  assign wrMode  = wrData && (idxReg == IX_MODE);
  assign rdFlag  = rdData && (idxReg == IX_FLAG);

  assign timeVec[0] = timeSec;
  assign timeVec[1] = timeMin;
  assign timeVec[2] = timeHour;

  assign dividerOk = (rateReg[6:4] == DIV_RUN);
  assign setMode   = modeReg[7];
  assign irq       = flagReg[7];

  for (genvar g = 0; g < ALARM_N; g++) begin : gAlarm
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(2 * g + 1);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) alarmReg[g] <= '0;
      else if (wrData && idxReg == MY_IDX) alarmReg[g] <= busWdata;
    end
    assign alarmHit[g] = (alarmReg[g][7:6] == 2'b11) || (alarmReg[g] == timeVec[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxReg <= '0;
    else if (wrIndex) idxReg <= busWdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateReg <= RATE_RST[DATA_W-2:0];
      modeReg <= MODE_RST;
    end else if (wrData) begin
      if (idxReg == IX_RATE) rateReg <= busWdata[DATA_W-2:0];
      if (idxReg == IX_MODE) modeReg <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) uipFlag <= 1'b0;
    else if (wrMode && busWdata[7]) uipFlag <= 1'b0;
    else if (strobe.finish) uipFlag <= 1'b0;
    else if (strobe.raiseUip) uipFlag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) calLoad <= 1'b0;
    else calLoad <= wrMode && modeReg[7] && !busWdata[7];
  end

  always_comb begin
    flagNext = rdFlag ? '0 : flagReg;
    if (strobe.finish) begin
      if (modeReg[5] && (&alarmHit)) flagNext = flagNext | 8'hA0;
      if (modeReg[4]) flagNext = flagNext | 8'h90;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagReg <= '0;
    else flagReg <= flagNext;
  end

  always_comb begin
    busRdata = '0;
    if (rdData) begin
      case (idxReg)
        IX_SEC:  busRdata = timeSec;
        IX_MIN:  busRdata = timeMin;
        IX_HOUR: busRdata = timeHour;
        7'd1:    busRdata = alarmReg[0];
        7'd3:    busRdata = alarmReg[1];
        7'd5:    busRdata = alarmReg[2];
        IX_RATE: busRdata = {uipFlag, rateReg};
        IX_MODE: busRdata = modeReg;
        IX_FLAG: busRdata = flagReg;
        IX_STAT: busRdata = STAT_VAL;
        default: busRdata = '0;
      endcase
    end
  end

  assert_uip_at_adv_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> uipFlag);

  assert_set_clears_uip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrMode && busWdata[7]) |=> !uipFlag);

  assert_read_clears_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdFlag && !strobe.finish) |=> !irq);

  assert_flag_summary_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg[5] || flagReg[4]) |-> irq);
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int LEAD_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic       busRe,
  input  logic       busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       secTick,
  input  logic [7:0] timeSec,
  input  logic [7:0] timeMin,
  input  logic [7:0] timeHour,
  output logic       calAdvance,
  output logic       calHold,
  output logic       calLoad,
  output logic       irq
);
  rtc_pkg::upd_strobe_t strobe;
  logic dividerOk;
  logic setMode;

  rtc_ctrl #(.LEAD_CYCLES(LEAD_CYCLES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .secTick  (secTick),
    .dividerOk(dividerOk),
    .setMode  (setMode),
    .strobe   (strobe)
  );

  rtc_regs uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busRe    (busRe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .timeSec  (timeSec),
    .timeMin  (timeMin),
    .timeHour (timeHour),
    .strobe   (strobe),
    .dividerOk(dividerOk),
    .setMode  (setMode),
    .calLoad  (calLoad),
    .irq      (irq)
  );

  assign calAdvance = strobe.advance;
  assign calHold    = setMode;
endmodule

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
  localparam int LEAD = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0, busAddr = 1'b0, secTick = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] tSec, tMin, tHour;
  logic calAdvance, calHold, calLoad, irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  bit running = 0;

  always #2 clk = ~clk;

  rtc_core #(.LEAD_CYCLES(LEAD)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .secTick(secTick),
    .timeSec(tSec), .timeMin(tMin), .timeHour(tHour),
    .calAdvance(calAdvance), .calHold(calHold), .calLoad(calLoad), .irq(irq)
  );

  // Behavioural reference model
  int mIdx, mA, mUip, mB, mC, mLoad, mPh, mCnt;
  int mAl [3];
  int setOld, divOk, raise, adv, fin, hitAll, nC, nUip, nLoad, tv;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIdx = 0; mA = 'h26; mUip = 0; mB = 'h02; mC = 0; mLoad = 0; mPh = 0; mCnt = 0;
      mAl[0] = 0; mAl[1] = 0; mAl[2] = 0;
      tSec <= 8'd20; tMin <= 8'd7; tHour <= 8'd3;
    end else begin
      setOld = (mB >> 7) & 1;
      divOk  = ((mA >> 4) & 7) == 2;
      raise  = (mPh == 0 && secTick && divOk && !setOld);
      adv    = (mPh == 2 && !setOld);
      fin    = (mPh == 3 && !setOld);
      hitAll = 1;
      for (int k = 0; k < 3; k++) begin
        tv = (k == 0) ? int'(tSec) : (k == 1) ? int'(tMin) : int'(tHour);
        if (!(((mAl[k] & 'hC0) == 'hC0) || mAl[k] == tv)) hitAll = 0;
      end
      nC = (busRe && busAddr && mIdx == 12) ? 0 : mC;
      if (fin) begin
        if ((mB & 'h20) && hitAll) nC = nC | 'hA0;
        if (mB & 'h10) nC = nC | 'h90;
      end
      nLoad = (busWe && busAddr && mIdx == 11 && setOld && !busWdata[7]);
      if (busWe && busAddr && mIdx == 11 && busWdata[7]) nUip = 0;
      else if (fin) nUip = 0;
      else if (raise) nUip = 1;
      else nUip = mUip;
      if (mPh != 0 && setOld) begin mPh = 0; mCnt = 0; end
      else if (mPh == 0) begin mCnt = 0; if (raise) mPh = 1; end
      else if (mPh == 1) begin if (mCnt == LEAD - 1) mPh = 2; else mCnt++; end
      else if (mPh == 2) mPh = 3;
      else mPh = 0;
      if (adv) tSec <= (tSec == 8'd59) ? 8'd0 : tSec + 8'd1;
      if (busWe && !busAddr) mIdx = busWdata & 'h7f;
      if (busWe && busAddr) begin
        if (mIdx == 1 || mIdx == 3 || mIdx == 5) mAl[mIdx/2] = busWdata;
        if (mIdx == 10) mA = busWdata & 'h7f;
        if (mIdx == 11) mB = busWdata;
      end
      mC = nC; mUip = nUip; mLoad = nLoad;
    end
  end

  function automatic int expRd();
    if (!(busRe && busAddr)) return 0;
    case (mIdx)
      0: return tSec;
      2: return tMin;
      4: return tHour;
      1, 3, 5: return mAl[mIdx/2];
      10: return (mUip << 7) | mA;
      11: return mB;
      12: return mC;
      13: return 'h80;
      default: return 0;
    endcase
  endfunction

  function automatic string rdTag();
    case (mIdx)
      0, 2, 4: return "R12";
      10: return "R3";
      12: return "R9";
      13: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic cmp(string tag, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && running) begin
      #1;
      vectors++;
      cmp(rdTag(), int'(busRdata), expRd());
      cmp("R11", int'(irq), (mC >> 7) & 1);
      cmp("R6", int'(calAdvance), (mPh == 2 && !((mB >> 7) & 1)) ? 1 : 0);
      cmp("R4", int'(calHold), (mB >> 7) & 1);
      cmp("R4", int'(calLoad), mLoad);
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    cmp(tag, act, exp);
  endtask

  task automatic setIdx(input logic [7:0] v);
    @(negedge clk); busWe = 1; busAddr = 0; busWdata = v;
    @(negedge clk); busWe = 0;
  endtask

  task automatic putCur(input logic [7:0] v);
    @(negedge clk); busWe = 1; busAddr = 1; busWdata = v;
    @(negedge clk); busWe = 0; busAddr = 0;
  endtask

  task automatic putReg(input logic [7:0] idx, input logic [7:0] v);
    setIdx(idx); putCur(v);
  endtask

  task automatic getCur(output int v);
    @(negedge clk); busRe = 1; busAddr = 1;
    #1 v = int'(busRdata);
    @(negedge clk); busRe = 0; busAddr = 0;
  endtask

  task automatic getReg(input logic [7:0] idx, output int v);
    setIdx(idx); getCur(v);
  endtask

  task automatic tick();
    @(negedge clk); secTick = 1;
    @(negedge clk); secTick = 0;
  endtask

  task automatic settle();
    repeat (LEAD + 4) @(negedge clk);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1;
    running = 1;
    // R2 reset values, R10 status value
    getReg(8'd10, v); chk("R2", v, 'h26);
    getReg(8'd11, v); chk("R2", v, 'h02);
    getReg(8'd12, v); chk("R2", v, 'h00);
    getReg(8'd13, v); chk("R2", v, 'h80);
    getReg(8'd3, v);  chk("R2", v, 'h00);
    // R12 time bus reads and unmapped index
    getReg(8'd0, v); chk("R12", v, 20);
    getReg(8'd4, v); chk("R12", v, 3);
    getReg(8'h20, v); chk("R12", v, 0);
    // R1 index bit 7 dropped
    setIdx(8'h8B); getCur(v); chk("R1", v, 'h02);
    // R3 update-in-progress not writable
    putReg(8'd10, 8'hFF); getCur(v); chk("R3", v, 'h7F);
    putReg(8'd10, 8'hA6); getCur(v); chk("R3", v, 'h26);
    // R8 update-ended flag, R6 flag during update
    putReg(8'd11, 8'h12);
    setIdx(8'd10); tick(); getCur(v); chk("R6", v, 'hA6);
    settle(); getCur(v); chk("R6", v, 'h26);
    chk("R11", int'(irq), 1);
    getReg(8'd12, v); chk("R8", v, 'h90);
    getCur(v); chk("R9", v, 'h00);
    chk("R11", int'(irq), 0);
    getReg(8'd0, v); chk("R6", v, 21);
    // R7 alarm match with don't-care minutes
    putReg(8'd11, 8'h22);
    putReg(8'd1, tSec + 8'd1); putReg(8'd3, 8'hC0); putReg(8'd5, tHour);
    tick(); settle();
    getReg(8'd12, v); chk("R7", v, 'hA0);
    // R7 mismatch on seconds
    putReg(8'd1, tSec + 8'd5);
    tick(); settle();
    getReg(8'd12, v); chk("R7", v, 'h00);
    // R7 all don't-care plus R8 together
    putReg(8'd1, 8'hFF); putReg(8'd5, 8'hC3); putReg(8'd11, 8'h32);
    tick(); settle();
    getReg(8'd12, v); chk("R7", v, 'hB0);
    // R5 divider off: tick ignored
    putReg(8'd11, 8'h12); putReg(8'd10, 8'h06);
    setIdx(8'd10); tick(); getCur(v); chk("R5", v, 'h06);
    settle(); getReg(8'd12, v); chk("R5", v, 'h00);
    putReg(8'd10, 8'h26);
    // R4 set mode blocks ticks
    putReg(8'd11, 8'h92);
    chk("R4", int'(calHold), 1);
    tick(); settle();
    getReg(8'd12, v); chk("R4", v, 'h00);
    putReg(8'd11, 8'h12);
    // R4 set mode entered mid-update cancels it
    setIdx(8'd11);
    tick();
    repeat (2) @(negedge clk);
    putCur(8'h92);
    settle();
    getReg(8'd10, v); chk("R4", v, 'h26);
    getReg(8'd12, v); chk("R4", v, 'h00);
    putReg(8'd11, 8'h12);
    // R9 read in the update-end cycle: new flags survive
    getReg(8'd12, v);
    tick();
    repeat (LEAD + 1) @(negedge clk);
    busRe = 1; busAddr = 1;
    @(negedge clk); busRe = 0; busAddr = 0;
    getCur(v); chk("R9", v, 'h90);
    // R10 writes to flags and status ignored
    putReg(8'd12, 8'hFF); getCur(v); chk("R10", v, 'h00);
    putReg(8'd13, 8'h00); getCur(v); chk("R10", v, 'h80);
    repeat (4) @(negedge clk);
    running = 0;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule